// File: doc/BRIEF.md
# Power-Fail Write Guard

This block sits between a host and a byte-wide asynchronous static memory and keeps the array from being corrupted while the supply fails or comes back. Three comparator flags report the supply level: above the upper fail threshold, above the lower fail threshold, and above the battery switchover level. The block filters each flag and drives a four-state sequencer from the filtered levels. In the NORMAL state the host chip-enable, write-enable and output-enable strobes reach the memory unchanged. In every other state the memory is deselected, writes are blocked and the data bus is not driven.

When the supply falls below the switchover level, the block selects the backup battery. When power returns, protection stays on for a timed recovery interval. The interval restarts whenever the supply dips again before it finishes. The memory array, the analog comparators and the battery switch are outside the block.

Top module: `pwr_guard`

## Requirements
- R1: While reset is asserted, state_o is PROTECT (2'b01), wr_protect is 1, bat_sel is 0, mem_ce_n, mem_we_n and mem_oe_n are 1, and bus_drive_en is 0.
- R2: In NORMAL (state_o 2'b00), mem_ce_n, mem_we_n and mem_oe_n follow host_ce_n, host_we_n and host_oe_n in the same cycle, and wr_protect is 0.
- R3: When the supply is between the two fail thresholds (upper flag 0, lower flag 1), the block leaves NORMAL for PROTECT. The memory strobes then stay at 1 and bus_drive_en stays at 0, whatever the host strobes do.
- R4: When both fail flags are 0 and the switchover flag is 1, the block stays in PROTECT with writes blocked.
- R5: When the filtered switchover flag goes to 0 in any state, the block enters BATTERY (2'b10) and asserts bat_sel.
- R6: When the switchover flag returns to 1, bat_sel is released and the block goes back to PROTECT.
- R7: Once both fail flags are 1 in PROTECT, the block enters RECOVER (2'b11). It stays there for exactly REC_CYCLES clock cycles and then enters NORMAL.
- R8: If the upper flag drops during RECOVER, the block returns to PROTECT. The next recovery again takes the full REC_CYCLES cycles.
- R9: mem_we_n goes to 1 in the same cycle that wr_protect goes to 1, even if host_we_n is still 0.
- R10: bus_drive_en is 1 only in NORMAL with host_ce_n=0, host_oe_n=0 and host_we_n=1. It stays 0 in any cycle where chip-enable and write-enable fall together.
- R11: Each comparator flag passes through two synchronizer flops and is accepted only after FILT_LEN consecutive agreeing samples. A pulse shorter than FILT_LEN cycles has no effect on the state.
- R12: NORMAL is entered only from RECOVER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sup_hi_i | input | 1 | Supply above upper fail threshold |
| sup_lo_i | input | 1 | Supply above lower fail threshold |
| sup_bat_i | input | 1 | Supply above battery switchover level |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to the array |
| mem_we_n | output | 1 | Gated write enable to the array |
| mem_oe_n | output | 1 | Gated output enable to the array |
| bus_drive_en | output | 1 | Data bus output drive enable |
| bat_sel | output | 1 | Select backup battery |
| wr_protect | output | 1 | Write protection active |
| state_o | output | 2 | 00 NORMAL, 01 PROTECT, 10 BATTERY, 11 RECOVER |

## Verification
The hardest situation to reach is a supply dip in the middle of a recovery interval, because the dip must pass the filter but must land before the timer expires. The bench raises all flags, waits until RECOVER appears, waits part of the interval and then drops the upper flag long enough to pass the filter. Once the state is back in PROTECT, it raises the flag again and counts the RECOVER cycles to confirm a full restart. Noise rejection is checked with a pulse one sample shorter than the filter length, applied while the block is in NORMAL.

// File: rtl/pwr_guard.sv
module pwr_guard #(
  parameter int FILT_LEN   = 3,
  parameter int REC_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_hi_i,
  input  logic       sup_lo_i,
  input  logic       sup_bat_i,
  input  logic       host_ce_n,
  input  logic       host_we_n,
  input  logic       host_oe_n,
  output logic       mem_ce_n,
  output logic       mem_we_n,
  output logic       mem_oe_n,
  output logic       bus_drive_en,
  output logic       bat_sel,
  output logic       wr_protect,
  output logic [1:0] state_o
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam int CW = $clog2(REC_CYCLES + 1);
  localparam logic [2:0] FLT_RST = 3'b100;

  localparam logic [1:0] ST_NORMAL  = 2'b00;
  localparam logic [1:0] ST_PROTECT = 2'b01;
  localparam logic [1:0] ST_BATTERY = 2'b10;
  localparam logic [1:0] ST_RECOVER = 2'b11;

  logic [2:0] raw;
  logic [2:0] flt;
  logic [1:0] state;
  logic [CW-1:0] rec_cnt;
  logic norm;

  assign raw = {sup_bat_i, sup_lo_i, sup_hi_i};

  for (genvar i = 0; i < 3; i++) begin : g_flt
    logic s1, s2;
    logic [FW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1     <= FLT_RST[i];
        s2     <= FLT_RST[i];
        cnt    <= '0;
        flt[i] <= FLT_RST[i];
      end else begin
        s1 <= raw[i];
        s2 <= s1;
        if (s2 != flt[i]) begin
          if (cnt == FW'(FILT_LEN - 1)) begin
            flt[i] <= s2;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end
    end
  end

  wire hi_ok  = flt[0];
  wire lo_ok  = flt[1];
  wire bat_ok = flt[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_PROTECT;
      rec_cnt <= '0;
    end else if (!bat_ok) begin
      state   <= ST_BATTERY;
      rec_cnt <= '0;
    end else begin
      case (state)
        ST_NORMAL:  if (!hi_ok || !lo_ok) state <= ST_PROTECT;
        ST_BATTERY: state <= ST_PROTECT;
        ST_PROTECT: if (hi_ok && lo_ok) begin
          state   <= ST_RECOVER;
          rec_cnt <= '0;
        end
        default: begin
          if (!hi_ok || !lo_ok) begin
            state <= ST_PROTECT;
          end else if (rec_cnt == CW'(REC_CYCLES - 1)) begin
            state <= ST_NORMAL;
          end else begin
            rec_cnt <= rec_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign norm         = (state == ST_NORMAL);
  assign mem_ce_n     = norm ? host_ce_n : 1'b1;
  assign mem_we_n     = norm ? host_we_n : 1'b1;
  assign mem_oe_n     = norm ? host_oe_n : 1'b1;
  assign bus_drive_en = norm & ~host_ce_n & ~host_oe_n & host_we_n;
  assign bat_sel      = (state == ST_BATTERY);
  assign wr_protect   = ~norm;
  assign state_o      = state;
endmodule

module pwr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_we_n,
  input logic       mem_we_n,
  input logic       bus_drive_en,
  input logic       bat_sel,
  input logic       wr_protect,
  input logic [1:0] state_o
);
  // R9
  protect_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_protect |-> mem_we_n);
  // R5
  battery_protected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sel |-> (wr_protect && state_o == 2'b10));
  // R12
  normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_o == 2'b00) |-> $past(state_o) == 2'b11);
  // R10
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_en |-> (host_we_n && !wr_protect));
  // R6
  battery_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bat_sel) |-> state_o == 2'b01);
endmodule

bind pwr_guard pwr_guard_chk u_chk (.*);

// File: tb/pwr_guard_bench.sv
module pwr_guard_bench;
  localparam int FILT = 3;
  localparam int REC  = 20;

  logic clk = 0, rst_n = 0;
  logic hi = 0, lo = 0, bat = 1;
  logic ce_n = 1, we_n = 1, oe_n = 1;
  logic mce_n, mwe_n, moe_n, drv, bsel, wp;
  logic [1:0] st;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pwr_guard #(.FILT_LEN(FILT), .REC_CYCLES(REC)) u_pwr_guard (
    .clk(clk), .rst_n(rst_n), .sup_hi_i(hi), .sup_lo_i(lo), .sup_bat_i(bat),
    .host_ce_n(ce_n), .host_we_n(we_n), .host_oe_n(oe_n),
    .mem_ce_n(mce_n), .mem_we_n(mwe_n), .mem_oe_n(moe_n),
    .bus_drive_en(drv), .bat_sel(bsel), .wr_protect(wp), .state_o(st));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(input logic [1:0] s, input string req);
    int n = 0;
    while (st !== s && n < 200) begin cyc(1); n++; end
    chk(req, st, s);
  endtask

  task automatic count_recover(input string req);
    int n = 0;
    wait_state(2'b11, req);
    while (st === 2'b11 && n < 1000) begin cyc(1); n++; end
    chk(req, n, REC);
    chk(req, st, 2'b00);
  endtask

  task automatic t_reset;
    cyc(2);
    chk("R1", st, 2'b01);
    chk("R1", {wp, bsel, mce_n, mwe_n, moe_n, drv}, 6'b101110);
    rst_n = 1;
  endtask

  task automatic t_power_up;
    hi = 1; lo = 1; bat = 1;
    count_recover("R7");
  endtask

  task automatic t_pass;
    ce_n = 0; oe_n = 0; we_n = 1; #1;
    chk("R2", {mce_n, mwe_n, moe_n, drv, wp}, 5'b01010);
    we_n = 0; oe_n = 1; #1;
    chk("R2", {mce_n, mwe_n, moe_n, drv}, 4'b0010);
    cyc(1);
    ce_n = 1; we_n = 1; cyc(1);
    ce_n = 0; we_n = 0; oe_n = 0; #1;
    chk("R10", drv, 0);
    cyc(1); ce_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic t_glitch;
    int bad = 0;
    hi = 0; cyc(FILT - 1); hi = 1;
    for (int i = 0; i < 12; i++) begin cyc(1); if (st !== 2'b00) bad++; end
    chk("R11", bad, 0);
  endtask

  task automatic t_window;
    int prev_wp = 0, bad = 0;
    ce_n = 0; we_n = 0; oe_n = 1;
    cyc(1);
    hi = 0;
    for (int i = 0; i < 15; i++) begin
      cyc(1);
      if (wp && !mwe_n) bad++;
      if (!wp && mwe_n) bad++;
      prev_wp = wp;
    end
    chk("R9", bad, 0);
    chk("R3", st, 2'b01);
    ce_n = 0; we_n = 1; oe_n = 0; #1;
    chk("R3", {mce_n, mwe_n, moe_n, drv}, 4'b1110);
    ce_n = 1; oe_n = 1;
    lo = 0; cyc(15);
    chk("R4", {st, wp}, 3'b011);
  endtask

  task automatic t_battery;
    bat = 0;
    wait_state(2'b10, "R5");
    chk("R5", bsel, 1);
    bat = 1;
    wait_state(2'b01, "R6");
    chk("R6", bsel, 0);
  endtask

  task automatic t_restart;
    hi = 1; lo = 1;
    wait_state(2'b11, "R8");
    cyc(8);
    hi = 0;
    wait_state(2'b01, "R8");
    hi = 1;
    count_recover("R8");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_power_up();
        t_pass();
        t_glitch();
        t_window();
        t_battery();
        t_restart();
      end
      begin
        cyc(100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule